// File: doc/BRIEF.md
# Trace Capture Ring Buffer

This block records a stream of trace words into an internal circular RAM while capture is enabled. Words pass through a short formatter pipeline before they reach the RAM. A trigger input starts a post-trigger countdown. When the countdown expires, capture ends and the pipeline drains, so a host sees a window of history around the trigger.

A host reaches the block through a simple register port: a 7-bit address, write data, a write strobe and a read strobe. Read data is registered and valid in the cycle after the strobe. All registers are 32 bits wide:

| Address | Register |
|---|---|
| 0 | identification |
| 1 | RAM depth |
| 2 | RAM width |
| 3 | status |
| 4 | RAM data |
| 5 | read pointer |
| 6 | write pointer |
| 7 | post-trigger count |
| 8 | control |

To unload the ring from its oldest frame after a wrap, the host sets the read pointer equal to the write pointer. Each read of the RAM data register returns one frame and steps the read pointer on.

The sequencer has five states:

| State | Role |
|---|---|
| ST_IDLE | capture off |
| ST_ARMED | capturing, waiting for the trigger |
| ST_POST | capturing, counting down |
| ST_DRAIN | acquisition done, pipeline emptying |
| ST_DONE | finished |

Its transitions are:

| Transition | Event |
|---|---|
| T_ARM | a control write with bit 0 set, from any state, to ST_ARMED |
| T_HALT | a control write with bit 0 clear, from any state, to ST_IDLE |
| T_FIRE | trigger with a non-zero count, ST_ARMED to ST_POST |
| T_FIRE0 | trigger with a zero count, ST_ARMED to ST_DRAIN |
| T_EXPIRE | count at zero, ST_POST to ST_DRAIN |
| T_SETTLE | pipeline empty, ST_DRAIN to ST_DONE |

Top module: `trace_ring_capture`

## Requirements
- R1: After reset, the registers read as follows: identification = ID_CODE, depth = DEPTH (16), width = TW (24), status = 0x8, read pointer = 0, write pointer = 0, count = 0, control = 0.
- R2: Register read data appears in the cycle after the read strobe. Writes to addresses 0, 1, 2, 3 and 4 are ignored. Reading any address other than 4 has no side effect.
- R3: While capture is active, each valid word is stored at the write pointer FMT_STAGES cycles after acceptance, and the write pointer then increments modulo DEPTH.
- R4: Status bit 0 (full) is set when a RAM write moves the write pointer from DEPTH-1 to 0.
- R5: Status bit 1 (triggered) is set by the trigger input only in ST_ARMED. A trigger while idle is ignored.
- R6: After the trigger word, exactly N more words are accepted, where N is the count register. Status bit 2 (acquisition complete) is then set and no further word is accepted. The count register reads the remaining count.
- R7: Status bit 3 (pipeline empty) is 0 while accepted words are still pending, and returns to 1 within FMT_STAGES cycles after acceptance stops.
- R8: Each read of address 4 returns the frame at the read pointer in bits [TW-1:0], then increments the read pointer modulo DEPTH.
- R9: Control bit 0 enables capture. Writing it as 1 clears status bits 0 to 2 and re-arms. Writing it as 0 stops capture and preserves the flags. Control bit 1 (demultiplexed port mode) is stored and read back.
- R10: The read pointer (address 5), write pointer (address 6) and count (address 7) are software writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| trc_valid | input | 1 | trace word valid |
| trc_data | input | TW | trace word |
| trc_trigger | input | 1 | trigger event |
| reg_addr | input | 7 | register address |
| reg_wdata | input | 32 | register write data |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe |
| reg_rdata | output | 32 | registered read data |

## Verification
The hardest situation to reach from the ports is a trigger arriving after the write pointer has already wrapped. In that case the full flag, the count expiry and the oldest-first readout all interact. The bench streams twenty consecutive words into the sixteen-entry ring, with the trigger on word sixteen and a count of three. It then points the read pointer at the write pointer and unloads all sixteen frames, so the read pointer itself wraps. A second case fires the trigger with a zero count, so the trigger word is the last word accepted.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_POST,
        ST_DRAIN,
        ST_DONE
    } cap_state_t;

    localparam logic [6:0] A_IDENT = 7'd0;
    localparam logic [6:0] A_DEPTH = 7'd1;
    localparam logic [6:0] A_WIDTH = 7'd2;
    localparam logic [6:0] A_STAT  = 7'd3;
    localparam logic [6:0] A_RDAT  = 7'd4;
    localparam logic [6:0] A_RPTR  = 7'd5;
    localparam logic [6:0] A_WPTR  = 7'd6;
    localparam logic [6:0] A_TCNT  = 7'd7;
    localparam logic [6:0] A_CTRL  = 7'd8;

    localparam int STAT_FULL  = 0;
    localparam int STAT_TRIG  = 1;
    localparam int STAT_ACQ   = 2;
    localparam int STAT_EMPTY = 3;

endpackage

// File: rtl/trc_fmt_pipe.sv
module trc_fmt_pipe #(
    parameter int TW     = 24,
    parameter int STAGES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [TW-1:0] in_data,
    output logic          out_valid,
    output logic [TW-1:0] out_data,
    output logic          empty
);

    logic [STAGES-1:0] stg_v;
    logic [TW-1:0]     stg_d [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        stg_v[0] <= 1'b0;
                        stg_d[0] <= '0;
                    end else begin
                        stg_v[0] <= in_valid;
                        stg_d[0] <= in_data;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        stg_v[i] <= 1'b0;
                        stg_d[i] <= '0;
                    end else begin
                        stg_v[i] <= stg_v[i-1];
                        stg_d[i] <= stg_d[i-1];
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        out_valid = stg_v[STAGES-1];
        out_data  = stg_d[STAGES-1];
        empty     = (stg_v == '0);
    end

endmodule

// File: rtl/trc_ring_store.sv
module trc_ring_store #(
    parameter int TW    = 24,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [TW-1:0] wdata,
    input  logic          wp_load,
    input  logic [AW-1:0] wp_val,
    input  logic          rp_load,
    input  logic [AW-1:0] rp_val,
    input  logic          rp_adv,
    input  logic          clr_full,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          full,
    output logic [TW-1:0] rd_word
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [TW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (wp_load) begin
            wr_ptr <= wp_val;
        end else if (we) begin
            wr_ptr <= wr_ptr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (clr_full) begin
            full <= 1'b0;
        end else if (we && (wr_ptr == LAST)) begin
            full <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (rp_load) begin
            rd_ptr <= rp_val;
        end else if (rp_adv) begin
            rd_ptr <= rd_ptr + AW'(1);
        end
    end

    always_comb begin
        rd_word = mem[rd_ptr];
    end

endmodule

// File: rtl/trc_cap_fsm.sv
module trc_cap_fsm
    import trc_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic          ctl_en,
    input  logic          trig_in,
    input  logic          frame_in,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wval,
    input  logic          fmt_empty,
    output logic          accept,
    output logic          triggered,
    output logic          acq_done,
    output logic [CW-1:0] count,
    output cap_state_t    state
);

    cap_state_t state_q, state_d;
    logic [CW-1:0] count_q;
    logic trig_q, acq_q;
    logic cnt_zero;

    assign cnt_zero = (count_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: control writes (T_ARM / T_HALT) override all others
    always_comb begin
        state_d = state_q;
        if (ctl_wr) begin
            state_d = ctl_en ? ST_ARMED : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARMED: begin
                    if (trig_in) begin
                        state_d = cnt_zero ? ST_DRAIN : ST_POST;  // T_FIRE0 / T_FIRE
                    end
                end
                ST_POST:  if (cnt_zero) state_d = ST_DRAIN;       // T_EXPIRE
                ST_DRAIN: if (fmt_empty) state_d = ST_DONE;       // T_SETTLE
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        accept    = frame_in &&
                    ((state_q == ST_ARMED) || ((state_q == ST_POST) && !cnt_zero));
        triggered = trig_q;
        acq_done  = acq_q;
        count     = count_q;
        state     = state_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            acq_q  <= 1'b0;
        end else if (ctl_wr && ctl_en) begin
            trig_q <= 1'b0;
            acq_q  <= 1'b0;
        end else begin
            if (!ctl_wr && (state_q == ST_ARMED) && trig_in) begin
                trig_q <= 1'b1;
            end
            if ((state_d == ST_DRAIN) && (state_q != ST_DRAIN)) begin
                acq_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_wr) begin
            count_q <= cnt_wval;
        end else if ((state_q == ST_POST) && accept) begin
            count_q <= count_q - CW'(1);
        end
    end

endmodule

// File: rtl/trace_ring_capture.sv
module trace_ring_capture
    import trc_pkg::*;
#(
    parameter int          TW         = 24,
    parameter int          DEPTH      = 16,
    parameter int          FMT_STAGES = 3,
    parameter logic [31:0] ID_CODE    = 32'h7C0A_0001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trc_valid,
    input  logic [TW-1:0] trc_data,
    input  logic          trc_trigger,
    input  logic [6:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic          reg_wr,
    input  logic          reg_rd,
    output logic [31:0]   reg_rdata
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = 32;

    logic          accept, ram_we, fmt_empty;
    logic [TW-1:0] ram_wdata, rd_word;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          st_full, st_trig, st_acq;
    logic [CW-1:0] tcount;
    cap_state_t    cap_state;
    logic [1:0]    ctrl_q;

    logic ctl_wr, rp_wr, wp_wr, tc_wr, rp_adv, arm;
    logic [31:0] status_w, rd_mux;

    always_comb begin
        ctl_wr = reg_wr && (reg_addr == A_CTRL);
        rp_wr  = reg_wr && (reg_addr == A_RPTR);
        wp_wr  = reg_wr && (reg_addr == A_WPTR);
        tc_wr  = reg_wr && (reg_addr == A_TCNT);
        rp_adv = reg_rd && (reg_addr == A_RDAT);
        arm    = ctl_wr && reg_wdata[0];
    end

    trc_cap_fsm #(.CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_en    (reg_wdata[0]),
        .trig_in   (trc_trigger),
        .frame_in  (trc_valid),
        .cnt_wr    (tc_wr),
        .cnt_wval  (reg_wdata),
        .fmt_empty (fmt_empty),
        .accept    (accept),
        .triggered (st_trig),
        .acq_done  (st_acq),
        .count     (tcount),
        .state     (cap_state)
    );

    trc_fmt_pipe #(.TW(TW), .STAGES(FMT_STAGES)) u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (accept),
        .in_data   (trc_data),
        .out_valid (ram_we),
        .out_data  (ram_wdata),
        .empty     (fmt_empty)
    );

    trc_ring_store #(.TW(TW), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ram_we),
        .wdata    (ram_wdata),
        .wp_load  (wp_wr),
        .wp_val   (reg_wdata[AW-1:0]),
        .rp_load  (rp_wr),
        .rp_val   (reg_wdata[AW-1:0]),
        .rp_adv   (rp_adv),
        .clr_full (arm),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .full     (st_full),
        .rd_word  (rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 2'b00;
        end else if (ctl_wr) begin
            ctrl_q <= reg_wdata[1:0];
        end
    end

    always_comb begin
        status_w = '0;
        status_w[STAT_FULL]  = st_full;
        status_w[STAT_TRIG]  = st_trig;
        status_w[STAT_ACQ]   = st_acq;
        status_w[STAT_EMPTY] = fmt_empty;
    end

    always_comb begin
        unique case (reg_addr)
            A_IDENT: rd_mux = ID_CODE;
            A_DEPTH: rd_mux = 32'(DEPTH);
            A_WIDTH: rd_mux = 32'(TW);
            A_STAT:  rd_mux = status_w;
            A_RDAT:  rd_mux = 32'(rd_word);
            A_RPTR:  rd_mux = 32'(rd_ptr);
            A_WPTR:  rd_mux = 32'(wr_ptr);
            A_TCNT:  rd_mux = tcount;
            A_CTRL:  rd_mux = 32'(ctrl_q);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/trace_ring_capture_chk.sv
module trace_ring_capture_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trc_trigger,
    input logic          accept,
    input logic          ram_we,
    input logic          fmt_empty,
    input logic          st_full,
    input logic          st_trig,
    input logic          st_acq,
    input logic          rp_adv,
    input logic          rp_wr,
    input logic          wp_wr,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] rd_ptr
);

    p_wp_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_wr |=> (wr_ptr == $past(wr_ptr)) || (wr_ptr == $past(wr_ptr) + AW'(1)));

    p_wp_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !wp_wr) |=> (wr_ptr == $past(wr_ptr) + AW'(1)));

    p_full_on_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_full) |-> ($past(ram_we) && ($past(wr_ptr) == {AW{1'b1}})));

    p_trig_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_trig) |-> $past(trc_trigger));

    p_no_accept_after_acq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_acq |-> !accept);

    p_empty_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_empty |-> !ram_we);

    p_rp_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_adv && !rp_wr) |=> (rd_ptr == $past(rd_ptr) + AW'(1)));

endmodule

bind trace_ring_capture trace_ring_capture_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trc_trigger (trc_trigger),
    .accept      (accept),
    .ram_we      (ram_we),
    .fmt_empty   (fmt_empty),
    .st_full     (st_full),
    .st_trig     (st_trig),
    .st_acq      (st_acq),
    .rp_adv      (rp_adv),
    .rp_wr       (rp_wr),
    .wp_wr       (wp_wr),
    .wr_ptr      (wr_ptr),
    .rd_ptr      (rd_ptr)
);

// File: tb/trace_ring_capture_test.sv
`timescale 1ns/1ps
module trace_ring_capture_test;

    localparam int TW = 24;
    localparam logic [31:0] IDC = 32'h7C0A_0001;
    localparam logic [23:0] BASE = 24'hA00000;
    localparam int NVEC = 20;

    // {write, addr[6:0], data[31:0], expect[31:0], req[3:0]}
    localparam logic [75:0] VEC [NVEC] = '{
        {1'b0, 7'd0, 32'h0, IDC,     4'd1},   // R1 identification
        {1'b0, 7'd1, 32'h0, 32'd16,  4'd1},   // R1 depth
        {1'b0, 7'd2, 32'h0, 32'd24,  4'd1},   // R1 width
        {1'b0, 7'd3, 32'h0, 32'h8,   4'd1},   // R1 status
        {1'b0, 7'd5, 32'h0, 32'h0,   4'd1},   // R1 read pointer
        {1'b0, 7'd6, 32'h0, 32'h0,   4'd1},   // R1 write pointer
        {1'b0, 7'd7, 32'h0, 32'h0,   4'd1},   // R1 count
        {1'b0, 7'd8, 32'h0, 32'h0,   4'd1},   // R1 control
        {1'b1, 7'd0, 32'hFFFF, 32'h0, 4'd2},
        {1'b0, 7'd0, 32'h0, IDC,     4'd2},   // R2 ident write ignored
        {1'b1, 7'd3, 32'hF, 32'h0,   4'd2},
        {1'b0, 7'd3, 32'h0, 32'h8,   4'd2},   // R2 status write ignored
        {1'b1, 7'd7, 32'd5, 32'h0,   4'd10},
        {1'b0, 7'd7, 32'h0, 32'd5,   4'd10},  // R10 count
        {1'b1, 7'd5, 32'd3, 32'h0,   4'd10},
        {1'b0, 7'd5, 32'h0, 32'd3,   4'd10},  // R10 read pointer
        {1'b1, 7'd6, 32'd2, 32'h0,   4'd10},
        {1'b1, 7'd4, 32'h55, 32'h0,  4'd2},
        {1'b0, 7'd6, 32'h0, 32'd2,   4'd2},   // R2 data write ignored, R10
        {1'b0, 7'd5, 32'h0, 32'd3,   4'd2}    // R2 reads had no side effect
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trc_valid = 1'b0;
    logic [TW-1:0] trc_data = '0;
    logic trc_trigger = 1'b0;
    logic [6:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic reg_wr = 1'b0;
    logic reg_rd = 1'b0;
    logic [31:0] reg_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit stream_on = 1'b0;
    int sidx = 0;
    int trig_at = 1000;

    always #2.5 clk = ~clk;

    trace_ring_capture uut (
        .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid), .trc_data(trc_data),
        .trc_trigger(trc_trigger), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    always @(negedge clk) begin
        if (stream_on) begin
            trc_valid   = 1'b1;
            trc_data    = BASE + TW'(sidx);
            trc_trigger = (sidx == trig_at);
            sidx++;
        end else begin
            trc_valid   = 1'b0;
            trc_trigger = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run_stream(input int first_trig, input int cycles);
        @(posedge clk);
        sidx = 0;
        trig_at = first_trig;
        stream_on = 1'b1;
        repeat (cycles) @(posedge clk);
        stream_on = 1'b0;
        repeat (10) @(posedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v, wp1;
        repeat (4) @(posedge clk);
        #1 check("R1 rdata reset", reg_rdata, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][75]) begin
                wr(VEC[i][74:68], VEC[i][67:36]);
            end else begin
                rd(VEC[i][74:68], v);
                check($sformatf("R%0d table %0d", VEC[i][3:0], i), v, VEC[i][35:4]);
            end
        end
        check("R9 mode bit readback", 32'h0, 32'h0);
        wr(7'd8, 32'h2);
        rd(7'd8, v);
        check("R9 mode bit readback", v, 32'h2);

        // R6: trigger on word 5, count 2 -> words 0..7 captured
        wr(7'd6, 0); wr(7'd5, 0); wr(7'd7, 2); wr(7'd8, 1);
        run_stream(5, 14);
        rd(7'd3, v);  check("R6 status after post count", v, 32'hE);
        rd(7'd6, v);  check("R6 words captured", v, 32'd8);
        rd(7'd7, v);  check("R6 count remaining", v, 32'd0);
        for (int k = 0; k < 8; k++) begin
            rd(7'd4, v);
            check($sformatf("R8 frame %0d", k), v, 32'(BASE + TW'(k)));
        end
        rd(7'd5, v);  check("R8 read pointer advanced", v, 32'd8);

        // R4: wrap, trigger on word 16, count 3 -> 20 words
        wr(7'd6, 0); wr(7'd7, 3); wr(7'd8, 1);
        run_stream(16, 24);
        rd(7'd3, v);  check("R4 full with flags", v, 32'hF);
        rd(7'd6, v);  check("R3 write pointer wrapped", v, 32'd4);
        wr(7'd5, 4);
        for (int k = 4; k < 20; k++) begin
            rd(7'd4, v);
            check($sformatf("R8 oldest-first %0d", k), v, 32'(BASE + TW'(k)));
        end
        rd(7'd5, v);  check("R8 read pointer wrap", v, 32'd4);

        // R9: enable clears flags
        wr(7'd6, 0); wr(7'd7, 5); wr(7'd8, 1);
        rd(7'd3, v);  check("R9 flags cleared on enable", v, 32'h8);

        // R7 empty low during capture, R9 stop
        @(posedge clk);
        sidx = 0; trig_at = 1000; stream_on = 1'b1;
        repeat (3) @(posedge clk);
        rd(7'd3, v);  check("R7 pending during capture", v, 32'h0);
        wr(7'd8, 0);
        repeat (4) @(posedge clk);
        stream_on = 1'b0;
        repeat (10) @(posedge clk);
        rd(7'd6, wp1);
        check("R3 words stored before stop", 32'(wp1 != 0), 32'd1);
        rd(7'd3, v);  check("R7 empty after stop", v, 32'h8);

        // R5 trigger ignored while idle; R9 stopped capture stores nothing
        run_stream(0, 6);
        rd(7'd6, v);  check("R9 no capture when stopped", v, wp1);
        rd(7'd3, v);  check("R5 idle trigger ignored", v, 32'h8);

        // R6 zero count: trigger word is the last one
        wr(7'd6, 0); wr(7'd7, 0); wr(7'd8, 1);
        run_stream(0, 8);
        rd(7'd6, v);  check("R6 zero count single word", v, 32'd1);
        rd(7'd3, v);  check("R6 zero count status", v, 32'hE);
        wr(7'd5, 0);
        rd(7'd4, v);  check("R8 trigger word stored", v, 32'(BASE));

        summary();
    end

endmodule